// File: doc/BRIEF.md
# Seven-Channel DMA Register File and Start Control

This block is the programming interface of a seven-channel DMA controller. It sits on a 32-bit register bus inside a 128-byte window, keeps three configuration words for each channel (base address, block control, channel control), and keeps two global words (priority/enable and interrupt). The transfer engines sit outside the block. They read their configuration from flat output buses, and they receive a one-cycle start pulse from this block.

A channel is started by software writes alone. After any full-word write that lands in a channel's 16-byte slot, the block looks at that channel's control word as it stands after the write. A start pulse goes out when the busy flag is set and either the manual trigger flag is set or the sync mode field is nonzero. When the engine later raises its done line, the block drops the busy and trigger flags of that channel, which tells software the channel is idle again.

Top module: `dma_regblock`

## Requirements
- R1: Only addresses from 0x1F801080 to 0x1F8010FF with address bits 1:0 equal to 0 are decoded. Offset bits 6:4 select the slot (0 to 6 are channels, 7 is global) and bits 3:2 select the word. Reads outside the window return 0 and writes outside it change nothing.
- R2: In channel slot c, word 0 (base address), word 1 (block control) and word 2 (channel control) hold all 32 written bits, reserved bits included, and read back unchanged. Word 3 reads 0 and discards data.
- R3: After reset every channel word is 0, the global control word at offset 0x70 is 0x07654321 and the interrupt word at offset 0x74 is 0.
- R4: The global control word (0x70) and the interrupt word (0x74) are fully writable and read back all 32 bits. Offsets 0x78 and 0x7C read 0.
- R5: A full write to any word of channel slot c raises start_pulse[c] for exactly the one cycle after the write edge. This happens when the control word after that write has bit 24 (busy) = 1 and either bit 28 (trigger) = 1 or bits 10:9 (sync mode) are not 00.
- R6: No start pulse is produced when busy is 0, or when trigger is 0 and sync mode is 00. Writes to the global slot never produce a start pulse.
- R7: A high done[c] at a clock edge clears bits 24 and 28 of channel c's control word. Every other bit and every other channel is left as it was.
- R8: If done[c] and a write to channel c arrive in the same cycle, the written data is stored with bits 24 and 28 forced to 0, and no start pulse is produced.
- R9: An access counts only when bus_be is 4'hF. Partial writes change nothing and partial reads return 0.
- R10: chan_base_o, chan_blk_o and chan_ctrl_o always carry the stored words of each channel in 32-bit lanes (lane c at bits 32c+31:32c). Within a block-control lane, bits 15:0 are the block size and bits 31:16 are the block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| done_i | input | 7 | Per-channel transfer-complete strobe from the engines |
| start_pulse_o | output | 7 | Per-channel one-cycle start request |
| chan_base_o | output | 224 | Base address words, one lane per channel |
| chan_blk_o | output | 224 | Block control words, one lane per channel |
| chan_ctrl_o | output | 224 | Channel control words, one lane per channel |

## Verification
The bench targets the start condition from each side:
- trigger alone, sync mode alone, busy without either, and trigger without busy;
- a write to a non-control word of an armed channel.

A design that looked at the control word from before the write, or that started only on control-word writes, would give the wrong pulse pattern. A done that arrives together with a write is also tested: a block that let the write override the clear would leave busy set and fire a start.

The bench also covers the remaining corners:
- partial-width accesses and addresses just outside the window, which a loose decoder would accept;
- the padding word of a channel slot;
- the unusual reset value of the global control word;
- the lane positions on the configuration buses.

// File: rtl/dma_reg_pkg.sv
// Package dma_reg_pkg
// Shared constants, the word-select type and the start-condition helper for
// the DMA register block. Assumes a 32-bit, word-aligned register bus.
package dma_reg_pkg;

    localparam int          DATA_W       = 32;
    localparam int          OFF_W        = 7;            // 128-byte window
    localparam int          SLOT_W       = 3;            // 8 slots of 16 bytes
    localparam logic [31:0] WIN_BASE     = 32'h1F80_1080;
    localparam logic [31:0] GLOBAL_RESET = 32'h0765_4321;
    localparam int          BIT_BUSY     = 24;
    localparam int          BIT_TRIG     = 28;
    localparam int          SYNC_LO      = 9;
    localparam int          SYNC_HI      = 10;
    localparam logic [SLOT_W-1:0] GLOBAL_SLOT = 3'd7;

    // Word position inside a 16-byte slot
    typedef enum logic [1:0] {
        WSEL_W0 = 2'd0,
        WSEL_W1 = 2'd1,
        WSEL_W2 = 2'd2,
        WSEL_W3 = 2'd3
    } word_sel_e;

    // Mask of the bits the done strobe clears
    localparam logic [31:0] DONE_CLR_MASK = (32'h1 << BIT_BUSY) | (32'h1 << BIT_TRIG);

    // True when a control word asks for a transfer
    function automatic logic start_wanted(input logic [31:0] ctrl);
        return ctrl[BIT_BUSY] && (ctrl[BIT_TRIG] || (ctrl[SYNC_HI:SYNC_LO] != 2'b00));
    endfunction

endpackage

// File: rtl/dma_addr_decode.sv
// Module dma_addr_decode
// Turns a bus request into write/read strobes plus slot and word indices.
// Assumes: only full-word (all byte enables set), word-aligned accesses inside
// the window count; everything else is dropped here.
module dma_addr_decode
    import dma_reg_pkg::*;
#(
    parameter logic [31:0] BASE = WIN_BASE
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [31:0]       bus_addr,
    input  logic [3:0]        bus_be,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [SLOT_W-1:0] slot,
    output word_sel_e         wsel
);

    logic in_window;
    logic full_word;

    // Window match and access-width qualification
    always_comb begin
        in_window = (bus_addr[31:OFF_W] == BASE[31:OFF_W]) && (bus_addr[1:0] == 2'b00);
        full_word = (bus_be == 4'hF);
    end

    // Strobes and index fields
    always_comb begin
        wr_stb = bus_valid &&  bus_write && in_window && full_word;
        rd_stb = bus_valid && !bus_write && in_window && full_word;
        slot   = bus_addr[OFF_W-1:4];
        wsel   = word_sel_e'(bus_addr[3:2]);
    end

endmodule

// File: rtl/dma_chan_regs.sv
// Module dma_chan_regs
// The configuration words of one channel plus its start logic. The start is
// judged on the control value after the current write and any done clear, so
// a simultaneous done suppresses the start. Word 3 of the slot holds nothing.
module dma_chan_regs
    import dma_reg_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [SLOT_W-1:0] slot,
    input  word_sel_e         wsel,
    input  logic [31:0]       wdata,
    input  logic              done,
    output logic [31:0]       base_q,
    output logic [31:0]       blk_q,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       rd_data,
    output logic              start_q
);

    logic        hit;
    logic [31:0] ctrl_wr;
    logic [31:0] ctrl_next;

    // Next control value: write first, then the done clear on top
    always_comb begin
        hit       = wr_stb && (slot == SLOT_W'(IDX));
        ctrl_wr   = (hit && wsel == WSEL_W2) ? wdata : ctrl_q;
        ctrl_next = done ? (ctrl_wr & ~DONE_CLR_MASK) : ctrl_wr;
    end

    // Base and block-control storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            blk_q  <= '0;
        end else if (hit) begin
            if (wsel == WSEL_W0) base_q <= wdata;
            if (wsel == WSEL_W1) blk_q  <= wdata;
        end
    end

    // Control storage and one-cycle start request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            start_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_next;
            start_q <= hit && start_wanted(ctrl_next);
        end
    end

    // Read-back of the word selected by the bus
    always_comb begin
        unique case (wsel)
            WSEL_W0: rd_data = base_q;
            WSEL_W1: rd_data = blk_q;
            WSEL_W2: rd_data = ctrl_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_global_regs.sv
// Module dma_global_regs
// The priority/enable word and the interrupt word in the last slot. Both are
// plain storage here; interrupt behaviour belongs to another block.
module dma_global_regs
    import dma_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [SLOT_W-1:0] slot,
    input  word_sel_e         wsel,
    input  logic [31:0]       wdata,
    output logic [31:0]       prio_q,
    output logic [31:0]       irq_q,
    output logic [31:0]       rd_data
);

    logic hit;

    // Slot match for the global words
    always_comb hit = wr_stb && (slot == GLOBAL_SLOT);

    // Global word storage with the fixed priority reset pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= GLOBAL_RESET;
            irq_q  <= '0;
        end else if (hit) begin
            if (wsel == WSEL_W0) prio_q <= wdata;
            if (wsel == WSEL_W1) irq_q  <= wdata;
        end
    end

    // Read-back; the two upper words of the slot are empty
    always_comb begin
        unique case (wsel)
            WSEL_W0: rd_data = prio_q;
            WSEL_W1: rd_data = irq_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_regblock.sv
// Module dma_regblock
// Top of the DMA register file: decode, NUM_CH channel slots, the global
// slot, the read mux and the flat configuration buses for the engines.
// Assumes NUM_CH <= 7, since slot 7 is reserved for the global words.
module dma_regblock
    import dma_reg_pkg::*;
#(
    parameter int NUM_CH = 7,
    localparam int LANES_W = NUM_CH * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [31:0]        bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_CH-1:0]  done_i,
    output logic [NUM_CH-1:0]  start_pulse_o,
    output logic [LANES_W-1:0] chan_base_o,
    output logic [LANES_W-1:0] chan_blk_o,
    output logic [LANES_W-1:0] chan_ctrl_o
);

    logic              wr_stb;
    logic              rd_stb;
    logic [SLOT_W-1:0] slot;
    word_sel_e         wsel;
    logic [31:0]       ch_rd [NUM_CH];
    logic [31:0]       glob_rd;
    logic [31:0]       glob_prio_q;
    logic [31:0]       glob_irq_q;

    dma_addr_decode #(.BASE(WIN_BASE)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .slot      (slot),
        .wsel      (wsel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dma_chan_regs #(.IDX(c)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_stb),
            .slot    (slot),
            .wsel    (wsel),
            .wdata   (bus_wdata),
            .done    (done_i[c]),
            .base_q  (chan_base_o[c*DATA_W +: DATA_W]),
            .blk_q   (chan_blk_o[c*DATA_W +: DATA_W]),
            .ctrl_q  (chan_ctrl_o[c*DATA_W +: DATA_W]),
            .rd_data (ch_rd[c]),
            .start_q (start_pulse_o[c])
        );
    end

    dma_global_regs u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .slot    (slot),
        .wsel    (wsel),
        .wdata   (bus_wdata),
        .prio_q  (glob_prio_q),
        .irq_q   (glob_irq_q),
        .rd_data (glob_rd)
    );

    // Read mux: global slot, a populated channel slot, or zero
    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            if (slot == GLOBAL_SLOT) begin
                bus_rdata = glob_rd;
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (slot == SLOT_W'(i)) bus_rdata = ch_rd[i];
                end
            end
        end
    end

endmodule

// File: rtl/dma_regblock_chk.sv
// Module dma_regblock_chk
// Protocol checks on dma_regblock, attached through bind below.
module dma_regblock_chk
    import dma_reg_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_valid,
    input logic                     bus_write,
    input logic [3:0]               bus_be,
    input logic [31:0]              bus_rdata,
    input logic [NUM_CH-1:0]        done_i,
    input logic [NUM_CH-1:0]        start_pulse_o,
    input logic [NUM_CH*32-1:0]     chan_ctrl_o,
    input logic [31:0]              glob_prio_q
);

    // R3: the first cycle out of reset shows the fixed priority pattern
    assert_glob_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> glob_prio_q == GLOBAL_RESET);

    // R9: a partial read returns zero
    assert_partial_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_be != 4'hF) |-> bus_rdata == 32'h0);

    // R9: a partial write leaves the global word untouched
    assert_partial_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && bus_write && bus_be != 4'hF) |-> $stable(glob_prio_q));

    // R5: at most one channel starts per cycle, since only one write is possible
    assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse_o));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R5: a start follows a full write and sees busy set
        assert_start_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            start_pulse_o[g] |-> ($past(bus_valid && bus_write && bus_be == 4'hF)
                                  && chan_ctrl_o[g*32 + BIT_BUSY]));
        // R7: done clears busy and trigger
        assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            done_i[g] |=> (!chan_ctrl_o[g*32 + BIT_BUSY] && !chan_ctrl_o[g*32 + BIT_TRIG]));
        // R8: done in the same cycle suppresses any start
        assert_done_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
            done_i[g] |=> !start_pulse_o[g]);
    end

endmodule

bind dma_regblock dma_regblock_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_be        (bus_be),
    .bus_rdata     (bus_rdata),
    .done_i        (done_i),
    .start_pulse_o (start_pulse_o),
    .chan_ctrl_o   (chan_ctrl_o),
    .glob_prio_q   (glob_prio_q)
);

// File: tb/dma_regblock_tb.sv
// Directed bench for dma_regblock: one task per scenario, each checking itself.
module dma_regblock_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 7;
    localparam logic [31:0] WB = 32'h1F80_1080;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic [3:0]        bus_be = 4'h0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    done_i = '0;
    logic [NCH-1:0]    start_pulse_o;
    logic [NCH*32-1:0] chan_base_o;
    logic [NCH*32-1:0] chan_blk_o;
    logic [NCH*32-1:0] chan_ctrl_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_regblock #(.NUM_CH(NCH)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid     (bus_valid),
        .bus_write     (bus_write),
        .bus_addr      (bus_addr),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .done_i        (done_i),
        .start_pulse_o (start_pulse_o),
        .chan_base_o   (chan_base_o),
        .chan_blk_o    (chan_blk_o),
        .chan_ctrl_o   (chan_ctrl_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write; returns at the following negedge, where the start pulse is visible
    task automatic wr(input logic [31:0] addr, input logic [31:0] data,
                      input logic [3:0] be = 4'hF, input logic [NCH-1:0] dn = '0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr;
        bus_wdata = data; bus_be = be; done_i = dn;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = 4'h0; done_i = '0;
    endtask

    task automatic rd(input logic [31:0] addr, output logic [31:0] data,
                      input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr; bus_be = be;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0; bus_be = 4'h0;
    endtask

    task automatic pulse_done(input logic [NCH-1:0] dn);
        @(negedge clk); done_i = dn;
        @(negedge clk); done_i = '0;
    endtask

    function automatic logic [31:0] ch_addr(input int c, input int w);
        return WB + 32'(c * 16 + w * 4);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(WB + 32'h70, d); check("R3 global reset", d, 32'h0765_4321);
        rd(WB + 32'h74, d); check("R3 irq reset", d, 32'h0);
        rd(ch_addr(4, 2), d); check("R3 chan ctrl reset", d, 32'h0);
        check("R3 start idle", 32'(start_pulse_o), 32'h0);
    endtask

    task automatic t_chan_rw();
        logic [31:0] d;
        wr(ch_addr(1, 0), 32'hA5A5_0004);
        wr(ch_addr(1, 1), 32'h0003_0010);
        wr(ch_addr(1, 2), 32'h00E0_00FC);   // reserved bits set, no busy
        rd(ch_addr(1, 0), d); check("R2 base", d, 32'hA5A5_0004);
        rd(ch_addr(1, 1), d); check("R2 blk", d, 32'h0003_0010);
        rd(ch_addr(1, 2), d); check("R2 ctrl reserved", d, 32'h00E0_00FC);
        wr(ch_addr(1, 3), 32'hFFFF_FFFF);
        rd(ch_addr(1, 3), d); check("R2 pad word reads 0", d, 32'h0);
        check("R2 pad write no effect", chan_ctrl_o[32 +: 32], 32'h00E0_00FC);
    endtask

    task automatic t_global_rw();
        logic [31:0] d;
        wr(WB + 32'h70, 32'h1234_5678);
        wr(WB + 32'h74, 32'h80FF_8000);
        rd(WB + 32'h70, d); check("R4 prio rw", d, 32'h1234_5678);
        rd(WB + 32'h74, d); check("R4 irq rw", d, 32'h80FF_8000);
        wr(WB + 32'h78, 32'hDEAD_BEEF);
        rd(WB + 32'h78, d); check("R4 0x78 reads 0", d, 32'h0);
        rd(WB + 32'h7C, d); check("R4 0x7C reads 0", d, 32'h0);
    endtask

    task automatic t_start_trigger();
        wr(ch_addr(6, 2), 32'h1100_0002);
        check("R5 trigger start ch6", 32'(start_pulse_o), 32'h40);
        @(negedge clk);
        check("R5 pulse one cycle", 32'(start_pulse_o), 32'h0);
    endtask

    task automatic t_start_sync();
        wr(ch_addr(2, 2), 32'h0100_0401);
        check("R5 sync start ch2", 32'(start_pulse_o), 32'h04);
        wr(ch_addr(2, 0), 32'h0001_0000);
        check("R5 base write restarts", 32'(start_pulse_o), 32'h04);
        pulse_done(7'h04);
    endtask

    task automatic t_no_start();
        wr(ch_addr(0, 2), 32'h0100_0000);
        check("R6 busy only", 32'(start_pulse_o), 32'h0);
        wr(ch_addr(0, 2), 32'h1000_0600);
        check("R6 no busy", 32'(start_pulse_o), 32'h0);
        wr(WB + 32'h70, 32'h1100_0002);
        check("R6 global write no start", 32'(start_pulse_o), 32'h0);
    endtask

    task automatic t_done_clear();
        wr(ch_addr(5, 2), 32'h1107_0601);
        wr(ch_addr(4, 2), 32'h1100_0002);
        pulse_done(7'h20);
        check("R7 ch5 cleared", chan_ctrl_o[5*32 +: 32], 32'h0007_0601);
        check("R7 ch4 untouched", chan_ctrl_o[4*32 +: 32], 32'h1100_0002);
    endtask

    task automatic t_done_collide();
        wr(ch_addr(3, 2), 32'h1107_0603, 4'hF, 7'h08);
        check("R8 no start on collision", 32'(start_pulse_o), 32'h0);
        check("R8 stored with clear", chan_ctrl_o[3*32 +: 32], 32'h0007_0603);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        wr(ch_addr(3, 0), 32'h5555_5555, 4'h3);
        check("R9 partial write ignored", chan_base_o[3*32 +: 32], 32'h0);
        wr(ch_addr(3, 2), 32'h1100_0000, 4'h7);
        check("R9 partial no start", 32'(start_pulse_o), 32'h0);
        rd(WB + 32'h70, d, 4'h1); check("R9 partial read 0", d, 32'h0);
    endtask

    task automatic t_outside();
        logic [31:0] d;
        wr(WB - 32'h10, 32'h1100_0002);
        wr(WB + 32'h80, 32'h1100_0002);
        check("R1 outside no start", 32'(start_pulse_o), 32'h0);
        rd(WB + 32'h80, d); check("R1 above window reads 0", d, 32'h0);
        rd(WB + 32'h72, d); check("R1 unaligned reads 0", d, 32'h0);
        rd(WB + 32'h70, d); check("R1 global unchanged", d, 32'h1100_0002);
    endtask

    task automatic t_outputs();
        wr(ch_addr(6, 1), 32'h0020_0040);
        wr(ch_addr(6, 0), 32'h0000_1000);
        check("R10 blk size lane", 32'(chan_blk_o[6*32 +: 16]), 32'h0040);
        check("R10 blk count lane", 32'(chan_blk_o[6*32+16 +: 16]), 32'h0020);
        check("R10 base lane", chan_base_o[6*32 +: 32], 32'h0000_1000);
        check("R10 ctrl lane", chan_ctrl_o[6*32 +: 32], 32'h1100_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chan_rw();
        t_global_rw();
        t_start_trigger();
        t_start_sync();
        t_no_start();
        t_done_clear();
        t_done_collide();
        t_partial();
        t_outside();
        t_outputs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule